// File: doc/BRIEF.md
# Dual Half-Word Multiply-Accumulate Datapath

This block is the multiply-accumulate datapath of a single-issue signal-processing pipeline stage. Each accepted operation takes two 32-bit operands, a 64-bit accumulator value and an operation code. It produces its result on the following clock edge. The register file around it supplies the operands and stores the result, and is not part of the block.

The datapath can form one signed 16x16 product from a chosen half of each operand. It can also multiply a whole 32-bit word by a 16-bit half and keep the upper word of the result. A third mode takes the upper 32 bits of a full 32x32 product, with optional accumulate, subtract and rounding. The dual mode forms two packed half-word products at once. These can be summed or differenced, and the second operand's halves can optionally be exchanged first. The dual result goes into either a 32-bit or a 64-bit accumulator. A sticky overflow flag records signed overflow of any accumulating 32-bit operation.

Top module: `dmac_unit`

## Requirements
- R1: Codes 0 (single product) and 1 (single product plus acc_in[31:0]) multiply signed 16-bit halves of opa and opb. The half of opa is chosen by a_top and the half of opb by b_top, where 1 picks bits 31:16 and 0 picks bits 15:0.
- R2: Codes 2 and 3 multiply the whole signed opa by the signed half of opb chosen by b_top. They keep bits 47:16 of the 48-bit product, which rounds toward minus infinity. Code 3 adds acc_in[31:0] to that value.
- R3: In codes 4 and 5, the lower half of opa is paired with the lower half of opb, and the upper half with the upper half. Code 4 adds both products to acc_in[31:0]. Code 5 adds the lower-pair product minus the upper-pair product.
- R4: When swap_b is 1, the dual codes (4 to 7) exchange the two halves of opb before pairing.
- R5: Codes 6 (sum) and 7 (lower-pair minus upper-pair) add the dual result to the full 64-bit acc_in. They return all 64 bits, wrapping modulo 2^64.
- R6: Codes 8, 9 and 10 form the 64-bit signed product of opa and opb and return its upper 32 bits. Code 8 uses the product alone. Code 9 adds acc_in[31:0]·2^32 to it. Code 10 subtracts the product from acc_in[31:0]·2^32. When round is 1, 0x8000_0000 is added to the 64-bit value before the upper word is taken.
- R7: Codes 0 to 5 and 8 to 10 ignore acc_in[63:32] and return a 32-bit value sign-extended into result[63:32].
- R8: For codes 1, 3, 4 and 5, an exact result outside the signed 32-bit range wraps to its low 32 bits and sets q_flag. Once set, q_flag stays 1 until reset.
- R9: Codes 0, 2 and 6 to 15 never set q_flag, even when a 64-bit sum wraps.
- R10: An operation accepted with in_valid at a clock edge appears on result, with out_valid high, after that edge. While in_valid is low, result holds its value and out_valid is low on the next cycle.
- R11: The unused codes 11 to 15 produce a result of zero.
- R12: While rst_n is low, result is zero and out_valid and q_flag are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation issue strobe |
| op | input | 4 | Operation code (0 to 10 used) |
| swap_b | input | 1 | Exchange halves of opb for dual codes |
| a_top | input | 1 | Upper-half select for opa, single-product codes |
| b_top | input | 1 | Upper-half select for opb, single and word-by-half codes |
| round | input | 1 | Rounding for most-significant-word codes |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_in | input | 64 | Accumulator value |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Operation result |
| q_flag | output | 1 | Sticky 32-bit accumulate overflow |

## Verification
The assertions assume that in_valid, op and the operands are driven at known levels whenever rst_n is high. They also assume that op holds a defined four-bit value in any cycle where in_valid is high. The stimulus changes every input only on the falling clock edge and returns in_valid to zero after each issue, so each operation stands alone. A hold interval with changed operands is inserted to observe that the result does not move. The overflow cases are grouped after the table of vectors, with a reset in between, so the sticky flag from one case cannot mask the next.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_HMUL  = 4'd0,
        OP_HMLA  = 4'd1,
        OP_WMUL  = 4'd2,
        OP_WMLA  = 4'd3,
        OP_DADD  = 4'd4,
        OP_DSUB  = 4'd5,
        OP_DADDL = 4'd6,
        OP_DSUBL = 4'd7,
        OP_MMUL  = 4'd8,
        OP_MMLA  = 4'd9,
        OP_MMLS  = 4'd10
    } op_e;

endpackage

// File: rtl/dmac_lanes.sv
module dmac_lanes #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] a,
    input  logic [2*HW-1:0] b,
    input  logic            swap,
    input  logic            a_top,
    input  logic            b_top,
    output logic [2*HW-1:0] prod_lo,
    output logic [2*HW-1:0] prod_hi,
    output logic [2*HW-1:0] prod_sel
);
    localparam int W = 2 * HW;

    logic [W-1:0] b_x;
    logic [W-1:0] lane_p [2];

    assign b_x = swap ? {b[HW-1:0], b[W-1:HW]} : b;

    // one signed HW x HW multiplier per packed lane
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [HW-1:0] ah, bh;
        logic [W-1:0]  ax, bx;
        assign ah = a[g*HW +: HW];
        assign bh = b_x[g*HW +: HW];
        assign ax = {{HW{ah[HW-1]}}, ah};
        assign bx = {{HW{bh[HW-1]}}, bh};
        assign lane_p[g] = ax * bx;
    end

    assign prod_lo = lane_p[0];
    assign prod_hi = lane_p[1];

    // independent half-select product
    logic [HW-1:0] as_h, bs_h;
    logic [W-1:0]  as_x, bs_x;
    assign as_h = a_top ? a[W-1:HW] : a[HW-1:0];
    assign bs_h = b_top ? b[W-1:HW] : b[HW-1:0];
    assign as_x = {{HW{as_h[HW-1]}}, as_h};
    assign bs_x = {{HW{bs_h[HW-1]}}, bs_h};
    assign prod_sel = as_x * bs_x;

endmodule

// File: rtl/dmac_wordhalf.sv
module dmac_wordhalf #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] a,
    input  logic [2*HW-1:0] b,
    input  logic            b_top,
    output logic [2*HW-1:0] upper
);
    localparam int W  = 2 * HW;
    localparam int PW = 3 * HW;

    logic [HW-1:0] bh;
    logic [PW-1:0] ax, bx, prod;

    assign bh    = b_top ? b[W-1:HW] : b[HW-1:0];
    assign ax    = {{HW{a[W-1]}}, a};
    assign bx    = {{W{bh[HW-1]}}, bh};
    assign prod  = ax * bx;
    assign upper = prod[PW-1:HW];

endmodule

// File: rtl/dmac_msw.sv
module dmac_msw #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] a,
    input  logic [2*HW-1:0] b,
    input  logic [2*HW-1:0] acc,
    input  logic            acc_en,
    input  logic            sub,
    input  logic            round,
    output logic [2*HW-1:0] upper
);
    localparam int W  = 2 * HW;
    localparam int PW = 2 * W;

    logic [PW-1:0] ax, bx, prod, base, rnd_v, total;

    assign ax    = {{W{a[W-1]}}, a};
    assign bx    = {{W{b[W-1]}}, b};
    assign prod  = ax * bx;
    assign base  = acc_en ? {acc, {W{1'b0}}} : '0;
    assign rnd_v = round ? {{W{1'b0}}, 1'b1, {(W-1){1'b0}}} : '0;
    assign total = (sub ? (base - prod) : (base + prod)) + rnd_v;
    assign upper = total[PW-1:W];

endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
    import dmac_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op,
    input  logic            swap_b,
    input  logic            a_top,
    input  logic            b_top,
    input  logic            round,
    input  logic [2*HW-1:0] opa,
    input  logic [2*HW-1:0] opb,
    input  logic [4*HW-1:0] acc_in,
    output logic            out_valid,
    output logic [4*HW-1:0] result,
    output logic            q_flag
);
    localparam int W  = 2 * HW;
    localparam int LW = 2 * W;
    localparam int SW = W + 3;

    typedef struct packed {
        logic [LW-1:0] res;
        logic          vld;
        logic          sat;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [SW-1:0] sx_s(input logic [W-1:0] v);
        return {{(SW-W){v[W-1]}}, v};
    endfunction

    function automatic logic [LW-1:0] sx_l(input logic [W-1:0] v);
        return {{(LW-W){v[W-1]}}, v};
    endfunction

    logic [W-1:0] p_lo, p_hi, p_sel, wh_up, msw_up;
    op_e          opc;

    assign opc = op_e'(op);

    dmac_lanes #(.HW(HW)) u_lanes (
        .a(opa), .b(opb), .swap(swap_b), .a_top(a_top), .b_top(b_top),
        .prod_lo(p_lo), .prod_hi(p_hi), .prod_sel(p_sel)
    );

    dmac_wordhalf #(.HW(HW)) u_wordhalf (
        .a(opa), .b(opb), .b_top(b_top), .upper(wh_up)
    );

    dmac_msw #(.HW(HW)) u_msw (
        .a(opa), .b(opb), .acc(acc_in[W-1:0]),
        .acc_en(opc == OP_MMLA || opc == OP_MMLS),
        .sub(opc == OP_MMLS), .round(round), .upper(msw_up)
    );

    logic [SW-1:0] term, sum_s;
    logic [LW-1:0] r_full;
    logic          narrow, acc_use, ovf;

    always_comb begin
        term    = '0;
        r_full  = '0;
        narrow  = 1'b1;
        acc_use = 1'b0;
        case (opc)
            OP_HMUL:  term = sx_s(p_sel);
            OP_HMLA:  begin term = sx_s(p_sel); acc_use = 1'b1; end
            OP_WMUL:  term = sx_s(wh_up);
            OP_WMLA:  begin term = sx_s(wh_up); acc_use = 1'b1; end
            OP_DADD:  begin term = sx_s(p_lo) + sx_s(p_hi); acc_use = 1'b1; end
            OP_DSUB:  begin term = sx_s(p_lo) - sx_s(p_hi); acc_use = 1'b1; end
            OP_DADDL: begin narrow = 1'b0; r_full = acc_in + sx_l(p_lo) + sx_l(p_hi); end
            OP_DSUBL: begin narrow = 1'b0; r_full = acc_in + sx_l(p_lo) - sx_l(p_hi); end
            OP_MMUL, OP_MMLA, OP_MMLS: begin narrow = 1'b0; r_full = sx_l(msw_up); end
            default:  begin narrow = 1'b0; r_full = '0; end
        endcase
        sum_s = term + (acc_use ? sx_s(acc_in[W-1:0]) : '0);
        // exact value outside signed W-bit range when top bits disagree
        ovf   = narrow && acc_use &&
                !((&sum_s[SW-1:W-1]) || !(|sum_s[SW-1:W-1]));
        if (narrow) r_full = sx_l(sum_s[W-1:0]);

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.res = r_full;
        st_d.sat = st_q.sat | (in_valid & ovf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign q_flag    = st_q.sat;

    p_issue_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_res_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_flag |=> q_flag);

    p_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !q_flag && (op == 4'd0 || op == 4'd2 || op >= 4'd6)) |=> !q_flag);

endmodule

// File: tb/dmac_unit_test.sv
module dmac_unit_test;

    typedef struct packed {
        logic [23:0] tag;
        logic [3:0]  op;
        logic        sw;
        logic        ta;
        logic        tb;
        logic        rn;
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] acc;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{"R1", 4'd0, 1'b0,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'hFFFFFFFFFFFFFFFA},
        '{"R1", 4'd0, 1'b0,1'b1,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'h15},
        '{"R1", 4'd0, 1'b0,1'b0,1'b1,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'hFFFFFFFFFFFFFFF8},
        '{"R1", 4'd0, 1'b0,1'b1,1'b1,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'h1C},
        '{"R7", 4'd1, 1'b0,1'b1,1'b1,1'b0, 32'h0007FFFE, 32'h00040003, 64'hDEAD000000000064, 64'h80},
        '{"R2", 4'd2, 1'b0,1'b0,1'b0,1'b0, 32'h00010000, 32'h00040003, 64'h0, 64'h3},
        '{"R2", 4'd2, 1'b0,1'b0,1'b1,1'b0, 32'hFFFF0000, 32'h00040003, 64'h0, 64'hFFFFFFFFFFFFFFFC},
        '{"R2", 4'd2, 1'b0,1'b0,1'b0,1'b0, 32'hFFFFFFFF, 32'h00040003, 64'h0, 64'hFFFFFFFFFFFFFFFF},
        '{"R2", 4'd3, 1'b0,1'b0,1'b0,1'b0, 32'h00010000, 32'h00040003, 64'hA, 64'hD},
        '{"R3", 4'd4, 1'b0,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h3E8, 64'h3FE},
        '{"R4", 4'd4, 1'b1,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'hD},
        '{"R3", 4'd5, 1'b0,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'hFFFFFFFFFFFFFFDE},
        '{"R4", 4'd5, 1'b1,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0, 64'hFFFFFFFFFFFFFFE3},
        '{"R5", 4'd7, 1'b0,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h0000000100000000, 64'h00000000FFFFFFDE},
        '{"R5", 4'd6, 1'b0,1'b0,1'b0,1'b0, 32'h0007FFFE, 32'h00040003, 64'h7FFFFFFFFFFFFFFF, 64'h8000000000000015},
        '{"R6", 4'd8, 1'b0,1'b0,1'b0,1'b0, 32'h40000000, 32'h00000008, 64'h0, 64'h2},
        '{"R6", 4'd8, 1'b0,1'b0,1'b0,1'b0, 32'hFFFFFFFF, 32'h00000001, 64'h0, 64'hFFFFFFFFFFFFFFFF},
        '{"R6", 4'd8, 1'b0,1'b0,1'b0,1'b1, 32'hFFFFFFFF, 32'h00000001, 64'h0, 64'h0},
        '{"R6", 4'd8, 1'b0,1'b0,1'b0,1'b0, 32'h00008000, 32'h00010000, 64'h0, 64'h0},
        '{"R6", 4'd8, 1'b0,1'b0,1'b0,1'b1, 32'h00008000, 32'h00010000, 64'h0, 64'h1},
        '{"R6", 4'd9, 1'b0,1'b0,1'b0,1'b0, 32'h40000000, 32'h00000008, 64'h5, 64'h7},
        '{"R6", 4'd10,1'b0,1'b0,1'b0,1'b0, 32'h40000000, 32'h00000008, 64'h5, 64'h3},
        '{"R6", 4'd10,1'b0,1'b0,1'b0,1'b0, 32'h00000001, 32'h00000001, 64'h5, 64'h4},
        '{"R6", 4'd10,1'b0,1'b0,1'b0,1'b1, 32'h00000001, 32'h00000001, 64'h5, 64'h5},
        '{"R11",4'd15,1'b0,1'b0,1'b0,1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h0},
        '{"R8", 4'd4, 1'b0,1'b0,1'b0,1'b0, 32'h80008000, 32'h80008000, 64'hFFFFFFFF, 64'h000000007FFFFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        swap_b = 1'b0, a_top = 1'b0, b_top = 1'b0, round = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [63:0] acc_in = '0;
    logic        out_valid, q_flag;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmac_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .swap_b(swap_b), .a_top(a_top), .b_top(b_top), .round(round),
        .opa(opa), .opb(opb), .acc_in(acc_in),
        .out_valid(out_valid), .result(result), .q_flag(q_flag)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input logic s, input logic t_a,
                         input logic t_b, input logic r, input logic [31:0] x,
                         input logic [31:0] y, input logic [63:0] c);
        @(negedge clk);
        op = o; swap_b = s; a_top = t_a; b_top = t_b; round = r;
        opa = x; opb = y; acc_in = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: state while reset is held
        check("R12 result", result, 64'h0);
        check("R12 out_valid", {63'h0, out_valid}, 64'h0);
        check("R12 q_flag", {63'h0, q_flag}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VT[i].op, VT[i].sw, VT[i].ta, VT[i].tb, VT[i].rn,
                  VT[i].a, VT[i].b, VT[i].acc);
            check($sformatf("%s vec%0d", VT[i].tag, i), result, VT[i].exp);
            check("R10 out_valid after issue", {63'h0, out_valid}, 64'h1);
        end
        // R9: table holds wrapping 64-bit and MSW cases, no flag expected
        check("R9 q_flag after table", {63'h0, q_flag}, 64'h0);

        // R10: hold while idle with changed inputs
        @(negedge clk);
        op = 4'd0; opa = 32'h12345678; opb = 32'h7FFF7FFF; acc_in = '1;
        @(negedge clk);
        check("R10 out_valid idle", {63'h0, out_valid}, 64'h0);
        check("R10 result hold", result, 64'h000000007FFFFFFF);

        // R8: dual sum overflow wraps and flags
        issue(4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 32'h80008000, 32'h80008000, 64'h0);
        check("R8 dual overflow wrap", result, 64'hFFFFFFFF80000000);
        check("R8 dual overflow flag", {63'h0, q_flag}, 64'h1);
        issue(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2, 32'h3, 64'h0);
        check("R8 after clean op", result, 64'h6);
        check("R8 flag sticky", {63'h0, q_flag}, 64'h1);

        do_reset();
        check("R12 flag cleared", {63'h0, q_flag}, 64'h0);

        // R8: single product accumulate overflow
        issue(4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFFFFFF);
        check("R8 single mla wrap", result, 64'hFFFFFFFF80000000);
        check("R8 single mla flag", {63'h0, q_flag}, 64'h1);

        do_reset();
        // R8: dual difference negative overflow
        issue(4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00010000, 32'h00010000, 64'h80000000);
        check("R8 dual diff wrap", result, 64'h000000007FFFFFFF);
        check("R8 dual diff flag", {63'h0, q_flag}, 64'h1);

        do_reset();
        // R9: 64-bit accumulate wrap leaves flag clear
        issue(4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 32'h80008000, 32'h80008000, 64'h7FFFFFFFFFFFFFFF);
        check("R9 wide wrap value", result, 64'h800000007FFFFFFF);
        check("R9 wide wrap flag", {63'h0, q_flag}, 64'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule